// File: doc/BRIEF.md
# PCI Slot Hotplug Register Block

This block keeps the hotplug bookkeeping for the slots of a single PCI bus. It holds three per-slot masks: which slots are occupied, which slots may be removed, and which slots have a removal waiting for software. Software reaches that state through a window of four 32-bit registers. Plug and unplug events arrive as strobes from the slot logic. A cold plug (a device already present when the machine is built) is recorded silently. A hot plug or a hot unplug also sends a one-cycle request to set the hotplug bit in the general-purpose event status.

Software acknowledges a removal by writing a slot mask to the eject register. Only the lowest set bit of the written value is acted on. The block then clears that pending bit and sends an eject strobe to the slot logic. The present bit is dropped unless the slot holds a fixed device.

A bus reset first drains every pending removal, one slot per cycle, lowest slot first. It then rebuilds the masks: every slot except the fixed ones becomes removable, and the present mask is loaded from the occupied-slot input. While the drain runs, a busy output is high and register accesses and events are dropped.

Top module: `hpslot_regs`

## Requirements
- R1: After `rst_n` is released, the present and pending masks are zero, the removable mask is all ones, and `busy`, `eject_valid` and `gpe_set` are low.
- R2: A read of offset 0x0 returns the present mask ANDed with the removable mask, one bit per slot with slot n at bit n.
- R3: A read request accepted in cycle t raises `bus_rvalid` with `bus_rdata` in cycle t+1. Offset 0x4 returns the pending-removal mask, offset 0xC returns the removable mask, and offset 0x8 returns zero.
- R4: Writes to offsets 0x0, 0x4 and 0xC change nothing. An access with `bus_word` low, or with an address outside 0x0..0xF or not a multiple of 4, reads as zero and writes nothing.
- R5: A plug event with `plug_cold` low sets the slot's present bit and pulses `gpe_set` for exactly one cycle, in the cycle after the event.
- R6: A plug event with `plug_cold` high sets the slot's present bit and raises no `gpe_set`.
- R7: An unplug event sets the slot's pending bit and pulses `gpe_set` in the next cycle.
- R8: A write to offset 0x8 selects the lowest set bit of the value as the slot. The block clears that slot's pending bit and, in the next cycle, pulses `eject_valid` with that slot on `eject_slot`. A value with no slot bit set does nothing.
- R9: On an eject, a slot's present bit is cleared unless its `slot_fixed` bit is set, in which case the present bit stays set.
- R10: `hp_reset` raises `busy` in the next cycle. The block then ejects each pending slot in ascending order, one per cycle, with the same present-bit rule as R9. One cycle after the last eject it sets the removable mask to the inverse of `slot_fixed`, loads the present mask from `slot_occupied`, and drops `busy`. `busy` is therefore high for one cycle more than the number of pending slots.
- R11: While `busy` is high, and in the cycle `hp_reset` is sampled, reads produce no `bus_rvalid`, writes have no effect, and plug and unplug events are dropped with no `gpe_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hp_reset | input | 1 | Bus reset request: drain pending removals, then rebuild the masks |
| bus_rd | input | 1 | Register read request |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_word | input | 1 | High when the access is 4 bytes wide |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| busy | output | 1 | Drain or rebuild in progress |
| slot_fixed | input | NUM_SLOTS | Slots holding a device that cannot be removed |
| slot_occupied | input | NUM_SLOTS | Slots occupied, sampled at rebuild |
| plug_valid | input | 1 | Plug event strobe |
| plug_slot | input | SLOT_W | Slot of the plug event |
| plug_cold | input | 1 | High for a cold plug (no event raised) |
| unplug_valid | input | 1 | Unplug event strobe |
| unplug_slot | input | SLOT_W | Slot of the unplug event |
| eject_valid | output | 1 | Eject strobe to the slot logic |
| eject_slot | output | SLOT_W | Slot being ejected |
| gpe_set | output | 1 | One-cycle request to set event status bit 1 (value 0x2) |

## Verification
The assertions check the following on every cycle:
- an idle read returns data the next cycle;
- offset 0x8 and non-word reads return zero;
- a non-empty eject write always yields an eject strobe;
- hot events raise the status request and cold plugs do not;
- a bus reset raises busy;
- nothing gets through while busy.

Only the bench scenarios can show the contents of the masks:
- the exact eject order and cycle count of a drain;
- that a fixed slot keeps its present bit;
- that a masked write leaves the registers unchanged;
- what the rebuild produces from the fixed and occupied inputs.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;

    // register select, taken from byte offset bits [3:2]
    typedef enum logic [1:0] {
        SEL_UP     = 2'd0,
        SEL_DOWN   = 2'd1,
        SEL_EJECT  = 2'd2,
        SEL_REMOVE = 2'd3
    } hp_sel_e;

    typedef enum logic [0:0] {
        PH_IDLE  = 1'b0,
        PH_DRAIN = 1'b1
    } hp_phase_e;

    localparam int unsigned HP_DATA_W = 32;

endpackage

// File: rtl/hpslot_lowest_set.sv
module hpslot_lowest_set #(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/hpslot_read_mux.sv
module hpslot_read_mux
    import hpslot_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 32
) (
    input  hp_sel_e                sel,
    input  logic                   hit,
    input  logic [NUM_SLOTS-1:0]   present,
    input  logic [NUM_SLOTS-1:0]   removable,
    input  logic [NUM_SLOTS-1:0]   pending,
    output logic [HP_DATA_W-1:0]   word
);
    logic [NUM_SLOTS-1:0] pick;

    always_comb begin
        unique case (sel)
            SEL_UP:     pick = present & removable;
            SEL_DOWN:   pick = pending;
            SEL_REMOVE: pick = removable;
            default:    pick = '0;
        endcase
        word = '0;
        if (hit) begin
            word[NUM_SLOTS-1:0] = pick;
        end
    end
endmodule

// File: rtl/hpslot_regs.sv
module hpslot_regs
    import hpslot_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hp_reset,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_word,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  bus_rvalid,
    output logic                  busy,
    input  logic [NUM_SLOTS-1:0]  slot_fixed,
    input  logic [NUM_SLOTS-1:0]  slot_occupied,
    input  logic                  plug_valid,
    input  logic [SLOT_W-1:0]     plug_slot,
    input  logic                  plug_cold,
    input  logic                  unplug_valid,
    input  logic [SLOT_W-1:0]     unplug_slot,
    output logic                  eject_valid,
    output logic [SLOT_W-1:0]     eject_slot,
    output logic                  gpe_set
);
    typedef struct packed {
        hp_phase_e              phase;
        logic [NUM_SLOTS-1:0]   present;
        logic [NUM_SLOTS-1:0]   removable;
        logic [NUM_SLOTS-1:0]   pending;
        logic                   eject_v;
        logic [SLOT_W-1:0]      eject_s;
        logic                   gpe;
        logic                   rvalid;
        logic [HP_DATA_W-1:0]   rdata;
    } hp_state_t;

    hp_state_t st_q, st_d;

    // window decode
    logic     in_window;
    logic     acc_ok;
    hp_sel_e  sel;
    logic [HP_DATA_W-1:0] rd_word;

    assign in_window = (bus_addr[ADDR_W-1:4] == '0) && (bus_addr[1:0] == 2'b00);
    assign acc_ok    = in_window && bus_word;
    assign sel       = hp_sel_e'(bus_addr[3:2]);

    hpslot_read_mux #(.NUM_SLOTS(NUM_SLOTS)) u_rmux (
        .sel       (sel),
        .hit       (acc_ok),
        .present   (st_q.present),
        .removable (st_q.removable),
        .pending   (st_q.pending),
        .word      (rd_word)
    );

    // slot chosen by an eject write
    logic              ej_found;
    logic [SLOT_W-1:0] ej_idx;
    hpslot_lowest_set #(.WIDTH(NUM_SLOTS)) u_ej_pick (
        .vec   (bus_wdata[NUM_SLOTS-1:0]),
        .found (ej_found),
        .idx   (ej_idx)
    );

    // slot chosen by the reset drain
    logic              dr_found;
    logic [SLOT_W-1:0] dr_idx;
    hpslot_lowest_set #(.WIDTH(NUM_SLOTS)) u_dr_pick (
        .vec   (st_q.pending),
        .found (dr_found),
        .idx   (dr_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.eject_v = 1'b0;
        st_d.gpe     = 1'b0;
        st_d.rvalid  = 1'b0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (hp_reset) begin
                    st_d.phase = PH_DRAIN;
                end else begin
                    if (bus_rd) begin
                        st_d.rvalid = 1'b1;
                        st_d.rdata  = rd_word;
                    end
                    if (bus_wr && acc_ok && sel == SEL_EJECT && ej_found) begin
                        st_d.pending[ej_idx] = 1'b0;
                        if (!slot_fixed[ej_idx]) begin
                            st_d.present[ej_idx] = 1'b0;
                        end
                        st_d.eject_v = 1'b1;
                        st_d.eject_s = ej_idx;
                    end
                    // events are applied after the eject so they win on a tie
                    if (plug_valid) begin
                        st_d.present[plug_slot] = 1'b1;
                        if (!plug_cold) begin
                            st_d.gpe = 1'b1;
                        end
                    end
                    if (unplug_valid) begin
                        st_d.pending[unplug_slot] = 1'b1;
                        st_d.gpe = 1'b1;
                    end
                end
            end
            PH_DRAIN: begin
                if (dr_found) begin
                    st_d.pending[dr_idx] = 1'b0;
                    if (!slot_fixed[dr_idx]) begin
                        st_d.present[dr_idx] = 1'b0;
                    end
                    st_d.eject_v = 1'b1;
                    st_d.eject_s = dr_idx;
                end else begin
                    st_d.removable = ~slot_fixed;
                    st_d.present   = slot_occupied;
                    st_d.phase     = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase     <= PH_IDLE;
            st_q.present   <= '0;
            st_q.removable <= '1;
            st_q.pending   <= '0;
            st_q.eject_v   <= 1'b0;
            st_q.eject_s   <= '0;
            st_q.gpe       <= 1'b0;
            st_q.rvalid    <= 1'b0;
            st_q.rdata     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = st_q.rdata;
    assign bus_rvalid  = st_q.rvalid;
    assign busy        = (st_q.phase != PH_IDLE);
    assign eject_valid = st_q.eject_v;
    assign eject_slot  = st_q.eject_s;
    assign gpe_set     = st_q.gpe;

endmodule

// File: rtl/hpslot_regs_chk.sv
module hpslot_regs_chk #(
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hp_reset,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_word,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 bus_rvalid,
    input logic                 busy,
    input logic                 plug_valid,
    input logic                 plug_cold,
    input logic                 unplug_valid,
    input logic                 eject_valid,
    input logic                 gpe_set
);
    logic idle_go;
    assign idle_go = !busy && !hp_reset;

    // R3: an accepted read answers in the next cycle
    a_r3_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_go && bus_rd) |=> bus_rvalid);

    // R3: offset 0x8 reads as zero
    a_r3_eject_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_go && bus_rd && bus_word && bus_addr == ADDR_W'(8)) |=> (bus_rvalid && bus_rdata == 32'd0));

    // R4: a non-word read returns zero
    a_r4_narrow_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_go && bus_rd && !bus_word) |=> (bus_rdata == 32'd0));

    // R5: a hot plug requests the event bit
    a_r5_hot_plug_event: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_go && plug_valid && !plug_cold) |=> gpe_set);

    // R6: a cold plug alone raises no event
    a_r6_cold_plug_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_go && plug_valid && plug_cold && !unplug_valid) |=> !gpe_set);

    // R7: a hot unplug requests the event bit
    a_r7_unplug_event: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_go && unplug_valid) |=> gpe_set);

    // R8: a non-empty eject write always strobes an eject
    a_r8_eject_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_go && bus_wr && bus_word && bus_addr == ADDR_W'(8) && (bus_wdata[NUM_SLOTS-1:0] != '0)) |=> eject_valid);

    // R10: a bus reset raises busy
    a_r10_reset_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hp_reset) |=> busy);

    // R11: nothing passes while busy
    a_r11_busy_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy || hp_reset) && bus_rd) |=> !bus_rvalid);

    a_r11_busy_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || hp_reset) |=> !gpe_set);

endmodule

bind hpslot_regs hpslot_regs_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hp_reset     (hp_reset),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_word     (bus_word),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_rvalid   (bus_rvalid),
    .busy         (busy),
    .plug_valid   (plug_valid),
    .plug_cold    (plug_cold),
    .unplug_valid (unplug_valid),
    .eject_valid  (eject_valid),
    .gpe_set      (gpe_set)
);

// File: tb/tb_hpslot_regs.sv
`timescale 1ns/1ps
module tb_hpslot_regs;
    localparam int NS = 32;
    localparam int AW = 8;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hp_reset = 1'b0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid, busy;
    logic [NS-1:0] slot_fixed = 32'h0000_0200;
    logic [NS-1:0] slot_occupied = '0;
    logic          plug_valid = 1'b0, plug_cold = 1'b0, unplug_valid = 1'b0;
    logic [SW-1:0] plug_slot = '0, unplug_slot = '0;
    logic          eject_valid, gpe_set;
    logic [SW-1:0] eject_slot;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    hpslot_regs #(.NUM_SLOTS(NS), .ADDR_W(AW)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic word, input logic [31:0] exp, input string req);
        bus_rd = 1'b1; bus_addr = a; bus_word = word;
        step();
        bus_rd = 1'b0; bus_word = 1'b0;
        chk({req, " rvalid"}, 32'(bus_rvalid), 32'd1);
        chk({req, " rdata"}, bus_rdata, exp);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic word, input logic [31:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_word = word; bus_wdata = v;
        step();
        bus_wr = 1'b0; bus_word = 1'b0; bus_wdata = '0;
    endtask

    task automatic t_reset_state();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 eject", 32'(eject_valid), 0);
        chk("R1 gpe", 32'(gpe_set), 0);
        rd_chk(8'h0, 1, 32'h0, "R1 up");
        rd_chk(8'h4, 1, 32'h0, "R1 down");
        rd_chk(8'hC, 1, 32'hFFFF_FFFF, "R1 removable");
        rd_chk(8'h8, 1, 32'h0, "R3 eject reads zero");
    endtask

    task automatic t_plugs();
        plug_valid = 1; plug_slot = 5; plug_cold = 0;
        step(); plug_valid = 0;
        chk("R5 gpe pulse", 32'(gpe_set), 1);
        step();
        chk("R5 gpe one cycle", 32'(gpe_set), 0);
        rd_chk(8'h0, 1, 32'h0000_0020, "R2 up after hot plug");
        plug_valid = 1; plug_slot = 9; plug_cold = 1;
        step(); plug_valid = 0; plug_cold = 0;
        chk("R6 no gpe", 32'(gpe_set), 0);
        rd_chk(8'h0, 1, 32'h0000_0220, "R6 up after cold plug");
    endtask

    task automatic t_unplug();
        unplug_valid = 1; unplug_slot = 5;
        step(); unplug_valid = 0;
        chk("R7 gpe", 32'(gpe_set), 1);
        unplug_valid = 1; unplug_slot = 9;
        step(); unplug_valid = 0;
        rd_chk(8'h4, 1, 32'h0000_0220, "R7 down");
    endtask

    task automatic t_ignored();
        wr(8'h0, 1, 32'h0);
        wr(8'h4, 1, 32'h0);
        wr(8'hC, 1, 32'h0);
        rd_chk(8'h4, 1, 32'h0000_0220, "R4 down unchanged");
        rd_chk(8'hC, 1, 32'hFFFF_FFFF, "R4 removable unchanged");
        wr(8'h8, 0, 32'h0000_0220);
        chk("R4 narrow eject ignored", 32'(eject_valid), 0);
        wr(8'h18, 1, 32'h0000_0220);
        chk("R4 outside eject ignored", 32'(eject_valid), 0);
        rd_chk(8'h4, 1, 32'h0000_0220, "R4 down after masked writes");
        rd_chk(8'h10, 1, 32'h0, "R4 outside window");
        rd_chk(8'h6, 1, 32'h0, "R4 misaligned");
        rd_chk(8'h4, 0, 32'h0, "R4 narrow read");
    endtask

    task automatic t_eject();
        wr(8'h8, 1, 32'h0);
        chk("R8 zero value no eject", 32'(eject_valid), 0);
        wr(8'h8, 1, 32'h0000_0220);
        chk("R8 eject strobe", 32'(eject_valid), 1);
        chk("R8 eject slot", 32'(eject_slot), 5);
        rd_chk(8'h4, 1, 32'h0000_0200, "R8 only lowest bit cleared");
        rd_chk(8'h0, 1, 32'h0000_0200, "R9 non-fixed present cleared");
        wr(8'h8, 1, 32'h0000_0200);
        chk("R8 eject slot 9", 32'(eject_slot), 9);
        rd_chk(8'h4, 1, 32'h0, "R8 down empty");
        rd_chk(8'h0, 1, 32'h0000_0200, "R9 fixed present kept");
    endtask

    task automatic t_reset_empty();
        slot_occupied = 32'h0000_0200;
        hp_reset = 1; step(); hp_reset = 0;
        chk("R10 busy", 32'(busy), 1);
        step();
        chk("R10 busy one cycle", 32'(busy), 0);
        chk("R10 no eject", 32'(eject_valid), 0);
        rd_chk(8'hC, 1, 32'hFFFF_FDFF, "R10 removable rebuilt");
        rd_chk(8'h0, 1, 32'h0, "R10 up rebuilt");
    endtask

    task automatic t_reset_drain();
        plug_valid = 1; plug_slot = 3;
        step(); plug_valid = 0;
        unplug_valid = 1; unplug_slot = 12;
        step();
        unplug_slot = 3;
        step(); unplug_valid = 0;
        rd_chk(8'h4, 1, 32'h0000_1008, "R7 two pending");
        slot_occupied = 32'h0000_1200;
        hp_reset = 1; step(); hp_reset = 0;
        chk("R10 drain busy", 32'(busy), 1);
        chk("R10 drain starts next", 32'(eject_valid), 0);
        bus_rd = 1; bus_addr = 8'h4; bus_word = 1;
        unplug_valid = 1; unplug_slot = 20;
        step();
        bus_rd = 0; bus_word = 0; unplug_valid = 0;
        chk("R11 read dropped", 32'(bus_rvalid), 0);
        chk("R11 event dropped", 32'(gpe_set), 0);
        chk("R10 first eject", 32'(eject_valid), 1);
        chk("R10 first slot", 32'(eject_slot), 3);
        step();
        chk("R10 second eject", 32'(eject_valid), 1);
        chk("R10 second slot", 32'(eject_slot), 12);
        chk("R10 still busy", 32'(busy), 1);
        step();
        chk("R10 done", 32'(busy), 0);
        chk("R10 no extra eject", 32'(eject_valid), 0);
        rd_chk(8'h4, 1, 32'h0, "R11 down empty after drain");
        rd_chk(8'hC, 1, 32'hFFFF_FDFF, "R10 removable");
        rd_chk(8'h0, 1, 32'h0000_1000, "R10 up from occupied");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset_state();
        t_plugs();
        t_unplug();
        t_ignored();
        t_eject();
        t_reset_empty();
        t_reset_drain();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule